// File: doc/BRIEF.md
# Cascadable Product-Term Macrocell Array

This block is a small configurable sum-of-products logic array made of eight identical macrocells. Every macrocell reads one shared signal bus. The bus carries the dedicated inputs, the value seen at each pin and the buried feedback of every macrocell. It also carries the NAND foldback term of every macrocell. Each macrocell builds five product terms from bus literals, which are picked by static mask vectors. It ORs those terms into a local sum. It can also take in the sum of the macrocell below it through a one-way cascade link, so a single output can collect up to forty terms.

The sum goes to a storage element. That element can act as a D flop, a T flop or a transparent latch, or it can be bypassed so that the pin is purely combinational. Each macrocell drives one pin, gated by a configuration output enable, and a buried feedback onto the bus. The configuration inputs are treated as static. They change only between evaluations and never mid-cycle during normal use.

The bus bit order is fixed: the dedicated inputs come first, then one pin slot per macrocell, then one feedback slot per macrocell, then one foldback slot per macrocell. The masks are indexed in that order. The buried feedback is always taken from a clocked state bit, and the foldback reads only the part of the bus below the foldback slots. As a result, no configuration can close a combinational loop.

Top module: `pterm_cascade_array`

## Requirements
- R1: A product term is 1 exactly when at least one literal is selected, every bus bit in its true mask is 1 and every bus bit in its complement mask is 0. A term with both masks empty is 0. The local sum of a macrocell is the OR of its five terms.
- R2: The sum of macrocell i is its local OR, ORed with the sum of macrocell i-1 when the cascade enable of macrocell i-1 is set. Macrocell 0 receives 0. A term in any of the 40 positions of a fully enabled chain reaches macrocell 7.
- R3: The foldback of macrocell i is the NAND of the literals selected by its fold masks over the lower 20 bus bits. With empty fold masks it is 1. It appears on bus bit 20+i.
- R4: In D mode (mode code 0), the pin shows the sum captured at the last rising clock edge.
- R5: In T mode (mode code 1), the pin state inverts at a rising edge when the sum is 1 and holds when the sum is 0.
- R6: In latch mode (mode code 2), the pin follows the sum while the clock is high and holds the value the sum had at the falling edge while the clock is low.
- R7: In bypass mode (mode code 3), the pin equals the current sum combinationally.
- R8: The state bit of each macrocell drives bus bit 12+i whatever its output enable is. In D and T mode this state bit is the storage register. In latch and bypass mode it captures the sum at each rising edge.
- R9: Bus bit 4+i carries pad_in[i] when cfg_oe[i] is 0 and the state bit of macrocell i when it is 1. Bus bits 0 to 3 carry din. pad_oe equals cfg_oe.
- R10: A high rst at a rising edge clears every state bit to 0, and at a falling edge it clears every latch to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge for registers, high level opens latches |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 4 | Dedicated inputs, bus bits 0..3 |
| pad_in | input | 8 | Externally driven pin values |
| cfg_pt_true | input | 1120 | True-literal masks, term j of cell i at bits (i*5+j)*28 upward |
| cfg_pt_comp | input | 1120 | Complement-literal masks, same layout |
| cfg_fold_true | input | 160 | Foldback true masks, cell i at bits i*20 upward |
| cfg_fold_comp | input | 160 | Foldback complement masks, same layout |
| cfg_mode | input | 16 | Two-bit mode per cell: 0 D, 1 T, 2 latch, 3 bypass |
| cfg_cas_en | input | 8 | Forward cell i's sum to cell i+1 |
| cfg_oe | input | 8 | Pin output enable per cell |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |

## Verification
The assertions check the register behaviour on every cycle. A non-toggle cell must capture the prior sum, and a T cell must invert or hold according to the prior sum. The assertions also check that a set cascade enable carries a 1 to the next cell, that a bypassed pin matches its sum, and that the state bits are clear on the first cycle after reset. The bench scenarios are the only evidence for the rest. That includes the exact product-term and NAND arithmetic over chosen literals, the 40-position chain sweep and the latch holding while an input changes in the low phase. It also includes how the pin slot is steered by the output enable and how the pins react under random configurations.

// File: rtl/pca_pkg.sv
package pca_pkg;

    localparam int PT_PER_CELL = 5;

    typedef enum logic [1:0] {
        MODE_D     = 2'd0,
        MODE_T     = 2'd1,
        MODE_LATCH = 2'd2,
        MODE_COMB  = 2'd3
    } cell_mode_e;

    typedef struct packed {
        logic q;
        logic lat;
    } cell_state_t;

endpackage

// File: rtl/pca_pterm.sv
module pca_pterm #(
    parameter int W = 28
) (
    input  logic [W-1:0] lits,
    input  logic [W-1:0] tmask,
    input  logic [W-1:0] cmask,
    output logic         term
);
    logic any_sel;
    logic true_ok;
    logic comp_ok;

    assign any_sel = |(tmask | cmask);
    assign true_ok = ((lits & tmask) == tmask);
    assign comp_ok = ((~lits & cmask) == cmask);
    assign term    = any_sel & true_ok & comp_ok;
endmodule

// File: rtl/pca_macrocell.sv
module pca_macrocell
    import pca_pkg::*;
#(
    parameter int BASE_W = 20,
    parameter int N_FOLD = 8,
    localparam int BUS_W = BASE_W + N_FOLD
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [BASE_W-1:0]            base_bus,
    input  logic [N_FOLD-1:0]            fold_bus,
    input  logic [PT_PER_CELL*BUS_W-1:0] pt_true,
    input  logic [PT_PER_CELL*BUS_W-1:0] pt_comp,
    input  logic [BASE_W-1:0]            fold_true,
    input  logic [BASE_W-1:0]            fold_comp,
    input  cell_mode_e                   mode,
    input  logic                         sum,
    output logic                         local_or,
    output logic                         fold_o,
    output logic                         q_o,
    output logic                         pin_o
);
    logic [BUS_W-1:0]       bus;
    logic [PT_PER_CELL-1:0] terms;
    logic                   fold_and;
    cell_state_t            st;

    assign bus = {fold_bus, base_bus};

    for (genvar j = 0; j < PT_PER_CELL; j++) begin : g_term
        pca_pterm #(.W(BUS_W)) u_term (
            .lits (bus),
            .tmask(pt_true[j*BUS_W +: BUS_W]),
            .cmask(pt_comp[j*BUS_W +: BUS_W]),
            .term (terms[j])
        );
    end

    pca_pterm #(.W(BASE_W)) u_fold (
        .lits (base_bus),
        .tmask(fold_true),
        .cmask(fold_comp),
        .term (fold_and)
    );

    assign local_or = |terms;
    assign fold_o   = ~fold_and;

    always_ff @(posedge clk) begin
        if (rst)                 st.q <= 1'b0;
        else if (mode == MODE_T) st.q <= st.q ^ sum;
        else                     st.q <= sum;
    end

    always_ff @(negedge clk) begin
        if (rst) st.lat <= 1'b0;
        else     st.lat <= sum;
    end

    assign q_o = st.q;

    always_comb begin
        unique case (mode)
            MODE_D, MODE_T: pin_o = st.q;
            MODE_LATCH:     pin_o = clk ? sum : st.lat;
            default:        pin_o = sum;
        endcase
    end
endmodule

// File: rtl/pca_cascade.sv
module pca_cascade #(
    parameter int N = 8
) (
    input  logic [N-1:0] local_or,
    input  logic [N-1:0] cas_en,
    output logic [N-1:0] sum
);
    always_comb begin
        logic carry;
        carry = 1'b0;
        for (int i = 0; i < N; i++) begin
            sum[i] = local_or[i] | carry;
            carry  = cas_en[i] & sum[i];
        end
    end
endmodule

// File: rtl/pterm_cascade_array.sv
module pterm_cascade_array
    import pca_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int N_MC = 8,
    localparam int BASE_W = N_IN + 2*N_MC,
    localparam int BUS_W  = BASE_W + N_MC,
    localparam int PT_W   = PT_PER_CELL*BUS_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_IN-1:0]        din,
    input  logic [N_MC-1:0]        pad_in,
    input  logic [N_MC*PT_W-1:0]   cfg_pt_true,
    input  logic [N_MC*PT_W-1:0]   cfg_pt_comp,
    input  logic [N_MC*BASE_W-1:0] cfg_fold_true,
    input  logic [N_MC*BASE_W-1:0] cfg_fold_comp,
    input  logic [2*N_MC-1:0]      cfg_mode,
    input  logic [N_MC-1:0]        cfg_cas_en,
    input  logic [N_MC-1:0]        cfg_oe,
    output logic [N_MC-1:0]        pad_out,
    output logic [N_MC-1:0]        pad_oe
);
    logic [N_MC-1:0]   q_w;
    logic [N_MC-1:0]   fold_w;
    logic [N_MC-1:0]   lor_w;
    logic [N_MC-1:0]   sum_w;
    logic [N_MC-1:0]   pin_slot;
    logic [BASE_W-1:0] base_bus;

    for (genvar i = 0; i < N_MC; i++) begin : g_slot
        assign pin_slot[i] = cfg_oe[i] ? q_w[i] : pad_in[i];
    end

    assign base_bus = {q_w, pin_slot, din};

    pca_cascade #(.N(N_MC)) u_chain (
        .local_or(lor_w),
        .cas_en  (cfg_cas_en),
        .sum     (sum_w)
    );

    for (genvar i = 0; i < N_MC; i++) begin : g_cell
        pca_macrocell #(.BASE_W(BASE_W), .N_FOLD(N_MC)) u_cell (
            .clk      (clk),
            .rst      (rst),
            .base_bus (base_bus),
            .fold_bus (fold_w),
            .pt_true  (cfg_pt_true[i*PT_W +: PT_W]),
            .pt_comp  (cfg_pt_comp[i*PT_W +: PT_W]),
            .fold_true(cfg_fold_true[i*BASE_W +: BASE_W]),
            .fold_comp(cfg_fold_comp[i*BASE_W +: BASE_W]),
            .mode     (cell_mode_e'(cfg_mode[2*i +: 2])),
            .sum      (sum_w[i]),
            .local_or (lor_w[i]),
            .fold_o   (fold_w[i]),
            .q_o      (q_w[i]),
            .pin_o    (pad_out[i])
        );
    end

    assign pad_oe = cfg_oe;
endmodule

// File: rtl/pca_checker.sv
module pca_checker #(
    parameter int N_MC = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [2*N_MC-1:0] mode_v,
    input logic [N_MC-1:0]   cas_en,
    input logic [N_MC-1:0]   sum_v,
    input logic [N_MC-1:0]   q_v,
    input logic [N_MC-1:0]   pad_v
);
    p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (q_v == '0));

    for (genvar i = 0; i < N_MC; i++) begin : g_chk
        p_capture_r4: assert property (@(posedge clk) disable iff (rst)
            (mode_v[2*i +: 2] != 2'd1) |=> (q_v[i] == $past(sum_v[i])));

        p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
            (mode_v[2*i +: 2] == 2'd1 && sum_v[i]) |=> (q_v[i] != $past(q_v[i])));

        p_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (mode_v[2*i +: 2] == 2'd1 && !sum_v[i]) |=> $stable(q_v[i]));

        always_comb begin
            if (!rst && mode_v[2*i +: 2] == 2'd3) begin
                p_bypass_r7: assert (pad_v[i] == sum_v[i]);
            end
        end

        if (i < N_MC-1) begin : g_link
            always_comb begin
                if (!rst && cas_en[i] && sum_v[i]) begin
                    p_cascade_r2: assert (sum_v[i+1]);
                end
            end
        end
    end
endmodule

bind pterm_cascade_array pca_checker #(.N_MC(N_MC)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .mode_v(cfg_mode),
    .cas_en(cfg_cas_en),
    .sum_v (sum_w),
    .q_v   (q_w),
    .pad_v (pad_out)
);

// File: tb/pterm_cascade_array_tb_top.sv
`timescale 1ns/1ps
module pterm_cascade_array_tb_top;
    localparam int NI = 4;
    localparam int NM = 8;
    localparam int NP = 5;
    localparam int W0 = NI + 2*NM;
    localparam int W  = W0 + NM;
    localparam int PW = NP*W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NI-1:0]    din = '0;
    logic [NM-1:0]    pad_in = '0;
    logic [NM*PW-1:0] cfg_pt_true = '0;
    logic [NM*PW-1:0] cfg_pt_comp = '0;
    logic [NM*W0-1:0] cfg_fold_true = '0;
    logic [NM*W0-1:0] cfg_fold_comp = '0;
    logic [2*NM-1:0]  cfg_mode = '0;
    logic [NM-1:0]    cfg_cas_en = '0;
    logic [NM-1:0]    cfg_oe = '0;
    logic [NM-1:0]    pad_out;
    logic [NM-1:0]    pad_oe;

    int total = 0;
    int bad = 0;
    logic [NM-1:0] mq = '0;

    always #4 clk = ~clk;

    pterm_cascade_array dut_i (
        .clk(clk), .rst(rst), .din(din), .pad_in(pad_in),
        .cfg_pt_true(cfg_pt_true), .cfg_pt_comp(cfg_pt_comp),
        .cfg_fold_true(cfg_fold_true), .cfg_fold_comp(cfg_fold_comp),
        .cfg_mode(cfg_mode), .cfg_cas_en(cfg_cas_en), .cfg_oe(cfg_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic ref_term(logic [W-1:0] b, logic [W-1:0] t, logic [W-1:0] c);
        return (|(t | c)) && ((b & t) == t) && ((~b & c) == c);
    endfunction

    function automatic logic [NM-1:0] ref_sums();
        logic [W-1:0]  b;
        logic [NM-1:0] s;
        logic carry;
        logic orv;
        b = '0;
        b[NI-1:0] = din;
        for (int i = 0; i < NM; i++) begin
            b[NI+i]    = cfg_oe[i] ? mq[i] : pad_in[i];
            b[NI+NM+i] = mq[i];
        end
        for (int i = 0; i < NM; i++)
            b[W0+i] = ~ref_term({{NM{1'b0}}, b[W0-1:0]},
                                {{NM{1'b0}}, cfg_fold_true[i*W0 +: W0]},
                                {{NM{1'b0}}, cfg_fold_comp[i*W0 +: W0]});
        carry = 1'b0;
        for (int i = 0; i < NM; i++) begin
            orv = 1'b0;
            for (int j = 0; j < NP; j++)
                orv |= ref_term(b, cfg_pt_true[(i*NP+j)*W +: W], cfg_pt_comp[(i*NP+j)*W +: W]);
            s[i]  = orv | carry;
            carry = cfg_cas_en[i] & s[i];
        end
        return s;
    endfunction

    function automatic string mode_tag(int i);
        case (cfg_mode[2*i +: 2])
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string tag, int idx, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s pad[%0d] actual=%0b expected=%0b t=%0t", tag, idx, act, exp, $time);
        end
    endtask

    task automatic check_pads(string tag);
        logic [NM-1:0] s;
        logic e;
        s = ref_sums();
        for (int i = 0; i < NM; i++) begin
            e = (cfg_mode[2*i +: 2] < 2'd2) ? mq[i] : s[i];
            chk((tag == "") ? mode_tag(i) : tag, i, pad_out[i], e);
        end
    endtask

    // rising edge, then high-phase check at +3 and low-phase check at +7
    task automatic tick(string tag);
        logic [NM-1:0] s;
        @(posedge clk);
        s = ref_sums();
        for (int i = 0; i < NM; i++) begin
            if (rst)                          mq[i] = 1'b0;
            else if (cfg_mode[2*i +: 2] == 1) mq[i] = mq[i] ^ s[i];
            else                              mq[i] = s[i];
        end
        #3;
        if (!rst) check_pads(tag);
        #4;
        check_pads(tag);
        total++;
        if (pad_oe !== cfg_oe) begin
            bad++;
            $display("FAIL R9 pad_oe actual=%h expected=%h", pad_oe, cfg_oe);
        end
    endtask

    task automatic clear_cfg();
        cfg_pt_true = '0; cfg_pt_comp = '0;
        cfg_fold_true = '0; cfg_fold_comp = '0;
        cfg_cas_en = '0; cfg_oe = '0;
    endtask

    task automatic set_term(int mc, int j, logic [W-1:0] t, logic [W-1:0] c);
        cfg_pt_true[(mc*NP+j)*W +: W] = t;
        cfg_pt_comp[(mc*NP+j)*W +: W] = c;
    endtask

    function automatic logic [W-1:0] bitv(int k);
        logic [W-1:0] v;
        v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    function automatic logic [W-1:0] sparse();
        logic [W-1:0] v;
        for (int k = 0; k < W; k++) v[k] = ($urandom % 14) == 0;
        return v;
    endfunction

    initial begin
        #(8*150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R10: reset clears state even with a sum of 1
        clear_cfg();
        cfg_mode = {NM{2'd0}};
        set_term(0, 0, '0, bitv(0));
        cfg_mode[2*1 +: 2] = 2'd1;
        set_term(1, 0, '0, bitv(0));
        rst = 1'b1;
        tick("R10"); tick("R10");
        rst = 1'b0;
        tick("");

        // R1: true and complement literals, empty term
        clear_cfg();
        cfg_mode = {NM{2'd3}};
        set_term(0, 0, bitv(0), bitv(1));
        set_term(2, 4, bitv(2) | bitv(3), '0);
        for (int v = 0; v < 16; v++) begin
            din = 4'(v);
            tick("R1");
        end

        // R2: each of the 40 positions reaches cell 7
        clear_cfg();
        cfg_mode = {NM{2'd3}};
        cfg_cas_en = '1;
        din = 4'b0001;
        for (int a = 0; a < NM; a++)
            for (int j = 0; j < NP; j++) begin
                cfg_pt_true = '0;
                set_term(a, j, bitv(0), '0);
                tick("R2");
                chk("R2", 7, pad_out[7], 1'b1);
            end
        cfg_pt_true = '0;
        set_term(0, 1, bitv(0), '0);
        cfg_cas_en[3] = 1'b0;
        tick("R2");
        chk("R2", 5, pad_out[5], 1'b0);
        chk("R2", 3, pad_out[3], 1'b1);

        // R3: foldback NAND, empty fold is 1
        clear_cfg();
        cfg_mode = {NM{2'd3}};
        cfg_fold_true[2*W0 +: W0] = W0'(3);
        set_term(5, 0, bitv(W0+2), '0);
        set_term(4, 0, bitv(W0+3), '0);
        for (int v = 0; v < 4; v++) begin
            din = 4'(v);
            tick("R3");
            chk("R3", 5, pad_out[5], ~(din[0] & din[1]));
            chk("R3", 4, pad_out[4], 1'b1);
        end

        // R4, R5: D and T registers
        clear_cfg();
        cfg_mode = {2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd1, 2'd0};
        set_term(0, 0, bitv(0), '0);
        set_term(1, 0, bitv(0), '0);
        for (int n = 0; n < 12; n++) begin
            din = 4'($urandom % 2);
            tick("");
        end

        // R6: latch holds while low, comb follows
        clear_cfg();
        cfg_mode = {2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd2};
        set_term(0, 0, bitv(0), '0);
        set_term(1, 0, bitv(0), '0);
        din = 4'b0001;
        tick("R6");
        din = 4'b0000;
        #0.5;
        chk("R6", 0, pad_out[0], 1'b1);
        chk("R7", 1, pad_out[1], 1'b0);
        tick("R6");
        chk("R6", 0, pad_out[0], 1'b0);

        // R8, R9: pin slot steering and buried feedback
        clear_cfg();
        cfg_mode = {2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd0, 2'd3};
        set_term(1, 0, bitv(0), '0);
        set_term(6, 0, bitv(NI+1), '0);
        set_term(7, 0, bitv(NI+NM+1), '0);
        for (int n = 0; n < 16; n++) begin
            cfg_oe[1] = (n >= 8);
            din = 4'($urandom);
            pad_in = NM'($urandom);
            tick((n < 8) ? "R9" : "R8");
        end

        // random configurations
        for (int blk = 0; blk < 30; blk++) begin
            for (int k = 0; k < NM*NP; k++) begin
                cfg_pt_true[k*W +: W] = sparse();
                cfg_pt_comp[k*W +: W] = sparse();
            end
            for (int i = 0; i < NM; i++) begin
                cfg_fold_true[i*W0 +: W0] = W0'(sparse());
                cfg_fold_comp[i*W0 +: W0] = W0'(sparse());
            end
            cfg_mode   = 16'($urandom);
            cfg_cas_en = NM'($urandom);
            cfg_oe     = NM'($urandom);
            for (int n = 0; n < 15; n++) begin
                din = 4'($urandom);
                pad_in = NM'($urandom);
                tick("");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule